// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer with Capture

This block is a 16-bit timer that a host reaches through a small byte-wide register port. It runs either as one 16-bit counter or as two separate 8-bit counters. Each counter reloads from its own reload value when it wraps. A prescaled tick advances the counters. The tick is taken from one of three sources: the system clock divided by 12, an already synchronized external clock divided by 8, or a slow oscillator divided by 8.

In capture mode the reload registers hold a timestamp. Each falling edge of the slow oscillator copies the live count into them. The block can therefore measure the slow oscillator period against the selected timebase. Two sticky overflow flags and a one-cycle capture pulse are combined, under per-source gating, into a single interrupt request.

Top module: `split_reload_timer`

Register map (reg_addr_i):
- 0: control
- 1: count low byte
- 2: count high byte
- 3: reload low byte
- 4: reload high byte

Control bits:
- [7] high overflow flag
- [6] low overflow flag
- [5] low-overflow interrupt enable
- [4] capture enable
- [3] split mode
- [2] run
- [1:0] tick source select

## Requirements
- R1: After reset every register reads 0x00, and flag_hi_o, flag_lo_o and irq_o are low.
- R2: With split = 0 and run = 1, each tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets the high flag (control bit 7).
- R3: Every tick on which the low byte is 0xFF sets the low flag (control bit 6), in either mode. In 16-bit mode the low byte goes to 0x00, unless the full count wraps, in which case it reloads.
- R4: With split = 1, the two bytes are separate 8-bit counters. A byte at 0xFF loads its own reload byte on the next tick. A high-byte wrap sets the high flag.
- R5: With run = 0, the 16-bit counter holds. In split mode, run gates only the high byte, and the low byte keeps counting.
- R6: The flags are sticky. Only a control write changes them: that write loads bits 7:6, and a hardware set in the same cycle takes priority.
- R7: Select 00 gives one tick per 12 system clocks. Select 01 gives one tick per 8 rising edges of ext_clk_i. Select 11 gives one tick per 8 rising edges of slow_osc_i. Select 10 gives no ticks.
- R8: With capture enable = 1, a falling edge of slow_osc_i copies the 16-bit count into the reload registers. The copy lands two clocks after the edge and takes priority over a host write to a reload register in that cycle. With capture enable = 0, no copy happens.
- R9: irq_o = irq_en_i AND (high flag OR (low enable AND low flag) OR capture pulse). The capture pulse lasts one cycle and follows each capture.
- R10: Writes to addresses 1 to 4 load the addressed byte of the count or reload registers. A count write takes priority over a tick in the same cycle. reg_rdata_o shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External clock, already synchronized |
| slow_osc_i | input | 1 | Slow oscillator level |
| irq_en_i | input | 1 | Block-level interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| flag_hi_o | output | 1 | High overflow flag |
| flag_lo_o | output | 1 | Low overflow flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Most internal faults show up at the registers within one tick. A wrong carry or reload path gives a count readback that is off after the tick that crosses 0xFF or 0xFFFF. A missing flag update shows on flag_hi_o or flag_lo_o on the cycle after that tick. Prescaler faults are different: they show only as a wrong tick total over a fixed window, so the bench counts exact cycles from a known write edge. A late or lost capture, or wrong write priority, leaves a stale reload value and no irq_o pulse two clocks after the falling edge.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    SEL_SYS  = 2'b00,
    SEL_EXT  = 2'b01,
    SEL_RSVD = 2'b10,
    SEL_SLOW = 2'b11
  } tick_sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RL_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RL_HI  = 3'd4;
endpackage

// File: rtl/srt_edge.sv
`timescale 1ns/1ps
module srt_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic d_q, d_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= 1'b0;
      d_qq <= 1'b0;
    end else begin
      d_q  <= d_i;
      d_qq <= d_q;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = d_qq & ~d_q;
    end else begin : g_rise
      assign edge_o = d_q & ~d_qq;
    end
  endgenerate
endmodule

// File: rtl/srt_prescale.sv
`timescale 1ns/1ps
module srt_prescale #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (ev_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = ev_i && (cnt_q == LAST);
endmodule

// File: rtl/srt_counter.sv
`timescale 1ns/1ps
module srt_counter
  import srt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              split_i,
  input  logic              run_i,
  input  logic              cap_i,
  input  logic              wr_cnt_lo_i,
  input  logic              wr_cnt_hi_i,
  input  logic              wr_rl_lo_i,
  input  logic              wr_rl_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic [BYTE_W-1:0] rl_lo_o,
  output logic [BYTE_W-1:0] rl_hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam logic [BYTE_W-1:0] ALL1 = {BYTE_W{1'b1}};

  logic [BYTE_W-1:0] cnt_lo_q, cnt_hi_q, rl_lo_q, rl_hi_q;
  logic [BYTE_W-1:0] nxt_lo, nxt_hi;
  logic lo_adv, hi_adv, lo_wrap, hi_wrap;

  always_comb begin
    lo_adv  = tick_i && (split_i || run_i);
    hi_adv  = tick_i && run_i && (split_i || cnt_lo_q == ALL1);
    lo_wrap = lo_adv && (cnt_lo_q == ALL1);
    hi_wrap = hi_adv && (cnt_hi_q == ALL1);

    nxt_lo = cnt_lo_q;
    if (lo_wrap)     nxt_lo = (split_i || hi_wrap) ? rl_lo_q : '0;
    else if (lo_adv) nxt_lo = cnt_lo_q + 1'b1;

    nxt_hi = cnt_hi_q;
    if (hi_wrap)     nxt_hi = rl_hi_q;
    else if (hi_adv) nxt_hi = cnt_hi_q + 1'b1;
  end

  // count: host write beats tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else begin
      cnt_lo_q <= wr_cnt_lo_i ? wdata_i : nxt_lo;
      cnt_hi_q <= wr_cnt_hi_i ? wdata_i : nxt_hi;
    end
  end

  // reload: capture beats host write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_lo_q <= '0;
      rl_hi_q <= '0;
    end else if (cap_i) begin
      rl_lo_q <= cnt_lo_q;
      rl_hi_q <= cnt_hi_q;
    end else begin
      if (wr_rl_lo_i) rl_lo_q <= wdata_i;
      if (wr_rl_hi_i) rl_hi_q <= wdata_i;
    end
  end

  assign cnt_lo_o = cnt_lo_q;
  assign cnt_hi_o = cnt_hi_q;
  assign rl_lo_o  = rl_lo_q;
  assign rl_hi_o  = rl_hi_q;
  assign ovf_lo_o = lo_wrap;
  assign ovf_hi_o = hi_wrap;
endmodule

// File: rtl/split_reload_timer.sv
`timescale 1ns/1ps
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int SYS_DIV  = 12,
  parameter int EXT_DIV  = 8,
  parameter int SLOW_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              slow_osc_i,
  input  logic              irq_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              flag_hi_o,
  output logic              flag_lo_o,
  output logic              irq_o
);
  logic flag_hi_q, flag_lo_q, lo_ie_q, cap_en_q, split_q, run_q, cap_pulse_q;
  tick_sel_e sel_q;

  logic ext_rise, slow_rise, slow_fall;
  logic tick_sys, tick_ext, tick_slow, tick;
  logic cap;
  logic ovf_lo, ovf_hi;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi, rl_lo, rl_hi;
  logic wr_ctrl;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);

  srt_edge #(.FALLING(1'b0)) u_ext_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .edge_o(ext_rise));
  srt_edge #(.FALLING(1'b0)) u_slow_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(slow_osc_i), .edge_o(slow_rise));
  srt_edge #(.FALLING(1'b1)) u_slow_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(slow_osc_i), .edge_o(slow_fall));

  srt_prescale #(.DIV(SYS_DIV)) u_pre_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(1'b1), .tick_o(tick_sys));
  srt_prescale #(.DIV(EXT_DIV)) u_pre_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ext_rise), .tick_o(tick_ext));
  srt_prescale #(.DIV(SLOW_DIV)) u_pre_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(slow_rise), .tick_o(tick_slow));

  always_comb begin
    unique case (sel_q)
      SEL_SYS:  tick = tick_sys;
      SEL_EXT:  tick = tick_ext;
      SEL_SLOW: tick = tick_slow;
      default:  tick = 1'b0;
    endcase
  end

  assign cap = cap_en_q && slow_fall;

  srt_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .split_i    (split_q),
    .run_i      (run_q),
    .cap_i      (cap),
    .wr_cnt_lo_i(reg_we_i && reg_addr_i == A_CNT_LO),
    .wr_cnt_hi_i(reg_we_i && reg_addr_i == A_CNT_HI),
    .wr_rl_lo_i (reg_we_i && reg_addr_i == A_RL_LO),
    .wr_rl_hi_i (reg_we_i && reg_addr_i == A_RL_HI),
    .wdata_i    (reg_wdata_i),
    .cnt_lo_o   (cnt_lo),
    .cnt_hi_o   (cnt_hi),
    .rl_lo_o    (rl_lo),
    .rl_hi_o    (rl_hi),
    .ovf_lo_o   (ovf_lo),
    .ovf_hi_o   (ovf_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_hi_q   <= 1'b0;
      flag_lo_q   <= 1'b0;
      lo_ie_q     <= 1'b0;
      cap_en_q    <= 1'b0;
      split_q     <= 1'b0;
      run_q       <= 1'b0;
      sel_q       <= SEL_SYS;
      cap_pulse_q <= 1'b0;
    end else begin
      // hardware set beats host clear
      flag_hi_q   <= ovf_hi | (wr_ctrl ? reg_wdata_i[7] : flag_hi_q);
      flag_lo_q   <= ovf_lo | (wr_ctrl ? reg_wdata_i[6] : flag_lo_q);
      cap_pulse_q <= cap;
      if (wr_ctrl) begin
        lo_ie_q  <= reg_wdata_i[5];
        cap_en_q <= reg_wdata_i[4];
        split_q  <= reg_wdata_i[3];
        run_q    <= reg_wdata_i[2];
        sel_q    <= tick_sel_e'(reg_wdata_i[1:0]);
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {flag_hi_q, flag_lo_q, lo_ie_q, cap_en_q,
                               split_q, run_q, sel_q};
      A_CNT_LO: reg_rdata_o = cnt_lo;
      A_CNT_HI: reg_rdata_o = cnt_hi;
      A_RL_LO:  reg_rdata_o = rl_lo;
      A_RL_HI:  reg_rdata_o = rl_hi;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign flag_hi_o = flag_hi_q;
  assign flag_lo_o = flag_lo_q;
  assign irq_o     = irq_en_i && (flag_hi_q || (lo_ie_q && flag_lo_q) || cap_pulse_q);
endmodule

// File: rtl/srt_checker.sv
`timescale 1ns/1ps
module srt_checker
  import srt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              irq_en_i,
  input logic              irq_o,
  input logic              flag_hi_o,
  input logic              flag_lo_o,
  input logic              split,
  input logic              run,
  input logic [1:0]        sel,
  input logic              tick,
  input logic              cap,
  input logic [15:0]       count,
  input logic [15:0]       reload
);
  logic ctrl_wr, cnt_wr, hi_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == A_CTRL;
  assign cnt_wr  = reg_we_i && (reg_addr_i == A_CNT_LO || reg_addr_i == A_CNT_HI);
  assign hi_wr   = reg_we_i && reg_addr_i == A_CNT_HI;

  assert_flag_hi_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_hi_o && !ctrl_wr) |=> flag_hi_o);
  assert_flag_lo_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_lo_o && !ctrl_wr) |=> flag_lo_o);
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  assert_stopped_16_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split && !run && !cnt_wr && !ctrl_wr) |=> $stable(count));
  assert_stopped_hi_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && !run && !hi_wr && !ctrl_wr) |=> $stable(count[15:8]));
  assert_rsvd_no_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 2'b10) |-> !tick);
  assert_capture_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (reload == $past(count)));
endmodule

bind split_reload_timer srt_checker u_srt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .irq_en_i  (irq_en_i),
  .irq_o     (irq_o),
  .flag_hi_o (flag_hi_o),
  .flag_lo_o (flag_lo_o),
  .split     (split_q),
  .run       (run_q),
  .sel       (sel_q),
  .tick      (tick),
  .cap       (cap),
  .count     ({cnt_hi, cnt_lo}),
  .reload    ({rl_hi, rl_lo})
);

// File: tb/split_reload_timer_bench.sv
`timescale 1ns/1ps
module split_reload_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk = 1'b0, slow_osc = 1'b0, irq_en = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic fh, fl, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  split_reload_timer u_split_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .slow_osc_i(slow_osc),
    .irq_en_i(irq_en), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flag_hi_o(fh), .flag_lo_o(fl), .irq_o(irq));

  // split run hi lo rhi rlo ticks exp_hi exp_lo exp_fh exp_fl
  localparam logic [55:0] VECS [8] = '{
    {1'b0,1'b1,8'h12,8'h34,8'h00,8'h00,4'd3,8'h12,8'h37,1'b0,1'b0},
    {1'b0,1'b1,8'hFF,8'hFE,8'hAB,8'hCD,4'd3,8'hAB,8'hCE,1'b1,1'b1},
    {1'b0,1'b1,8'h12,8'hFE,8'h00,8'h00,4'd2,8'h13,8'h00,1'b0,1'b1},
    {1'b0,1'b0,8'h55,8'h55,8'h00,8'h00,4'd3,8'h55,8'h55,1'b0,1'b0},
    {1'b1,1'b1,8'h10,8'hFE,8'h80,8'h40,4'd3,8'h13,8'h41,1'b0,1'b1},
    {1'b1,1'b0,8'h20,8'h05,8'h00,8'h00,4'd4,8'h20,8'h09,1'b0,1'b0},
    {1'b1,1'b1,8'hFE,8'h00,8'h70,8'h00,4'd3,8'h71,8'h03,1'b1,1'b0},
    {1'b1,1'b1,8'hFF,8'hFF,8'h11,8'h22,4'd1,8'h11,8'h22,1'b1,1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (2) @(negedge clk);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_osc = 1'b1;
      repeat (2) @(negedge clk);
      slow_osc = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic set_count(input logic [15:0] c, input logic [15:0] r);
    wr(3'd3, r[7:0]);
    wr(3'd4, r[15:8]);
    wr(3'd1, c[7:0]);
    wr(3'd2, c[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R10 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      check(b == 8'h00, "R1 reset reg", b, 0);
    end
    check(!fh && !fl && !irq, "R1 reset outputs", {fh, fl, irq}, 0);

    // vector table, ext clock source (R2 R3 R4 R5 R7 R10)
    for (int i = 0; i < 8; i++) begin
      logic [55:0] t;
      t = VECS[i];
      wr(3'd0, {4'b0000, t[55], t[54], 2'b01});
      set_count(t[53:38], t[37:22]);
      pulse_ext(8 * int'(t[21:18]));
      rd16(v);
      check(v == t[17:2], "R2/R3/R4/R5 count", v, t[17:2]);
      check({fh, fl} == t[1:0], "R3/R6 flags", {fh, fl}, t[1:0]);
    end

    // R6 sticky flags, R9 gating
    wr(3'd0, 8'b0000_0101);
    set_count(16'hFFFF, 16'h0000);
    pulse_ext(8);
    repeat (20) @(negedge clk);
    check(fh && fl, "R6 flags stay set", {fh, fl}, 3);
    irq_en = 1'b1;
    #0.5 check(irq == 1'b1, "R9 irq from high flag", irq, 1);
    wr(3'd0, 8'b0100_0101);
    #0.5 check(irq == 1'b0 && fl && !fh, "R9 low flag masked", {fh, fl, irq}, 3'b010);
    wr(3'd0, 8'b0110_0101);
    #0.5 check(irq == 1'b1, "R9 low flag enabled", irq, 1);
    irq_en = 1'b0;
    #0.5 check(irq == 1'b0, "R9 block enable off", irq, 0);
    irq_en = 1'b1;
    wr(3'd0, 8'h00);
    #0.5 check(!fh && !fl && !irq, "R6 write clears", {fh, fl, irq}, 0);

    // R7 system clock / 12: exactly 5 ticks in 60 edges after arming write
    wr(3'd0, 8'b0000_0000);
    set_count(16'h0000, 16'h0000);
    wr(3'd0, 8'b0000_0100);
    repeat (60) @(posedge clk);
    rd16(v);
    check(v == 16'd5, "R7 sysclk div 12", v, 5);

    // R7 reserved select
    wr(3'd0, 8'b0000_0010);
    set_count(16'h0000, 16'h0000);
    wr(3'd0, 8'b0000_0110);
    pulse_ext(16);
    repeat (30) @(negedge clk);
    rd16(v);
    check(v == 16'd0, "R7 reserved select no ticks", v, 0);

    // R7 slow oscillator / 8
    wr(3'd0, 8'b0000_0011);
    set_count(16'h0000, 16'h0000);
    wr(3'd0, 8'b0000_0111);
    pulse_slow(16);
    rd16(v);
    check(v == 16'd2, "R7 slow div 8", v, 2);

    // R8 capture beats same-cycle reload write, R9 capture pulse
    wr(3'd0, 8'b0001_0001);
    set_count(16'hBEEF, 16'h0000);
    @(negedge clk) slow_osc = 1'b1;
    repeat (4) @(negedge clk);
    slow_osc = 1'b0;
    @(posedge clk);
    @(negedge clk);
    we = 1'b1; addr = 3'd3; wdata = 8'h55;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    #0.5 check(irq == 1'b1, "R9 capture pulse", irq, 1);
    @(negedge clk);
    #0.5 check(irq == 1'b0, "R9 capture pulse one cycle", irq, 0);
    rd(3'd3, b);
    check(b == 8'hEF, "R8 capture low beats write", b, 8'hEF);
    rd(3'd4, b);
    check(b == 8'hBE, "R8 capture high", b, 8'hBE);

    // R8 capture disabled
    wr(3'd0, 8'b0000_0001);
    set_count(16'h4321, 16'h1234);
    pulse_slow(1);
    rd(3'd3, b);
    check(b == 8'h34, "R8 no capture when disabled", b, 8'h34);
    check(irq == 1'b0, "R9 no pulse without capture", irq, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule